// File: doc/BRIEF.md
# Eight-Cell Discrete-Time Cellular Neural Array

This block runs a one-dimensional cellular neural network with eight cells, all of them in lockstep. Each cell holds a wide state value. On every active cycle the cell forms two three-tap weighted sums. The first is a feedback sum over the limited outputs of itself and its two neighbours. The second is a control sum over the same three cells' fixed inputs. A bias is added to both sums, along with a leak of minus the current state. The total is scaled by a power-of-two step and accumulated into the state, which is a forward-Euler integration. Each cell output is the state clamped to the range minus one to plus one.

A host writes the feedback weights, the control weights, the bias, an iteration count, the eight cell inputs and the eight initial states through a write-only register port. A start pulse then loads the initial states. The array iterates the programmed number of times and raises a done flag. The flag holds, with the state frozen, until the next start. All values use signed 16-bit fixed point with 12 fraction bits. Inputs in [-1, +1] come from mapping a pixel level p in [0,1] to 2p−1 before writing.

Top module: `cnn1d_array`

## Requirements
- R1: After reset, every cell state and cell output reads zero, and `busy` and `done` are low.
- R2: A write with `cfg_we` high while idle and without `start` is stored at `cfg_addr`. The map is: 0, 1, 2 = feedback weight for the left, self and right neighbour. 3, 4, 5 = control weight for left, self and right. 6 = bias. 7 = iteration count. 8+k = input of cell k. 16+k = initial state of cell k. Other addresses store nothing.
- R3: Writes while `busy` is high are ignored, and the running iteration uses the values stored before it.
- R4: A `start` pulse loads each cell state with its initial value and clears the iteration counter. One cycle after the start edge, `cell_x` shows the initial states and `cell_y` shows them clamped.
- R5: Each weighted sum is s = sat18(Σ (w_j·v_j >>> 12)), with one term for each of the left, self and right taps. Here >>> is an arithmetic (floor) shift and sat18 clamps to [−131072, 131071]. The neighbour value is zero left of cell 0 and right of cell 7.
- R6: In each iteration cycle, every 32-bit state x becomes x + ((−x + sA + sB + bias) >>> 4). Here sA is the feedback sum over the current outputs and sB is the control sum over the inputs, both sign-extended.
- R7: Each cell output is its state clamped to [−4096, +4096], which is [−1, +1].
- R8: `cell_x` shows each state saturated to the 16-bit range [−32768, 32767].
- R9: With an iteration count N ≥ 1, `done` rises exactly N cycles after the start edge and `busy` is high in between. With N = 0, `done` is high one cycle after start and no update happens. After `done`, state and outputs hold and `done` stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register index |
| cfg_wdata | input | 16 | Configuration write data, signed Q3.12 |
| start | input | 1 | Load initial states and begin iterating |
| busy | output | 1 | High while iterations remain |
| done | output | 1 | Programmed iteration count reached |
| cell_y | output | 128 | Cell outputs, cell k in bits 16k+15:16k |
| cell_x | output | 128 | Saturated cell states, same packing |

## Verification
The assertions check, on every cycle, the things that hold at all times. Outputs never leave [−1, +1] and follow the state inside that range. A state holds when neither loading nor stepping. Configuration stays fixed while busy. Start clears the counter, `done` rises only when the count matches, and `done` and `busy` are never high together. Only the bench's scenarios can show that the arithmetic is right. It compares every state and output after the run against a model of the sums, the boundary zeros and the Euler step. It also covers saturation of the state in both directions, the zero-iteration case, and writes made during a run that must leave the result unchanged.

// File: rtl/cnn1d_pkg.sv
package cnn1d_pkg;
    localparam int DATA_W_DEF  = 16;
    localparam int FRAC_W_DEF  = 12;
    localparam int SUM_W_DEF   = 18;
    localparam int STATE_W_DEF = 32;
    localparam int NCELL_DEF   = 8;
    localparam int STEP_SH_DEF = 4;

    // register map of the configuration port
    localparam int ADDR_FB0  = 0;   // feedback taps: left, self, right
    localparam int ADDR_CT0  = 3;   // control taps: left, self, right
    localparam int ADDR_BIAS = 6;
    localparam int ADDR_ITER = 7;
    localparam int ADDR_IN0  = 8;   // cell inputs, then initial states
endpackage

// File: rtl/cnn1d_tap3.sv
module cnn1d_tap3 #(
    parameter int W     = cnn1d_pkg::DATA_W_DEF,
    parameter int FRAC  = cnn1d_pkg::FRAC_W_DEF,
    parameter int SUM_W = cnn1d_pkg::SUM_W_DEF
) (
    input  logic signed [W-1:0]     w_l,
    input  logic signed [W-1:0]     w_c,
    input  logic signed [W-1:0]     w_r,
    input  logic signed [W-1:0]     v_l,
    input  logic signed [W-1:0]     v_c,
    input  logic signed [W-1:0]     v_r,
    output logic signed [SUM_W-1:0] res
);
    localparam int ACC_W = 2 * W + 2;
    localparam logic signed [ACC_W-1:0] HI = ACC_W'((2 ** (SUM_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] LO = ACC_W'(-(2 ** (SUM_W - 1)));

    logic signed [2*W-1:0] p_l, p_c, p_r;
    logic signed [ACC_W-1:0] acc;

    always_comb begin
        p_l = w_l * v_l;
        p_c = w_c * v_c;
        p_r = w_r * v_r;
        acc = ACC_W'(p_l >>> FRAC) + ACC_W'(p_c >>> FRAC) + ACC_W'(p_r >>> FRAC);
        if (acc > HI)      res = HI[SUM_W-1:0];
        else if (acc < LO) res = LO[SUM_W-1:0];
        else               res = acc[SUM_W-1:0];
    end
endmodule

// File: rtl/cnn1d_cell.sv
module cnn1d_cell #(
    parameter int W       = cnn1d_pkg::DATA_W_DEF,
    parameter int FRAC    = cnn1d_pkg::FRAC_W_DEF,
    parameter int SUM_W   = cnn1d_pkg::SUM_W_DEF,
    parameter int STATE_W = cnn1d_pkg::STATE_W_DEF,
    parameter int STEP_SH = cnn1d_pkg::STEP_SH_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    step,
    input  logic signed [W-1:0]     x_init,
    input  logic signed [SUM_W-1:0] fb_sum,
    input  logic signed [SUM_W-1:0] ct_sum,
    input  logic signed [W-1:0]     bias,
    output logic signed [W-1:0]     x_out,
    output logic signed [W-1:0]     y_out
);
    localparam int ONE_I = 1 << FRAC;
    localparam logic signed [STATE_W-1:0] ONE_S = STATE_W'(ONE_I);
    localparam logic signed [STATE_W-1:0] XMAX  = STATE_W'((2 ** (W - 1)) - 1);
    localparam logic signed [STATE_W-1:0] XMIN  = STATE_W'(-(2 ** (W - 1)));

    typedef struct packed {
        logic signed [STATE_W-1:0] x;
        logic signed [W-1:0]       y;
    } cell_t;

    cell_t c_d, c_q;
    logic signed [STATE_W-1:0] inc;

    function automatic logic signed [W-1:0] limit(input logic signed [STATE_W-1:0] v);
        if (v > ONE_S)       return W'(ONE_I);
        else if (v < -ONE_S) return W'(-ONE_I);
        else                 return v[W-1:0];
    endfunction

    always_comb begin
        c_d = c_q;
        inc = -c_q.x + STATE_W'(fb_sum) + STATE_W'(ct_sum) + STATE_W'(bias);
        if (load)      c_d.x = STATE_W'(x_init);
        else if (step) c_d.x = c_q.x + (inc >>> STEP_SH);
        c_d.y = limit(c_d.x);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        y_out = c_q.y;
        if (c_q.x > XMAX)      x_out = XMAX[W-1:0];
        else if (c_q.x < XMIN) x_out = XMIN[W-1:0];
        else                   x_out = c_q.x[W-1:0];
    end

    AST_Y_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (STATE_W'(c_q.y) <= ONE_S) && (STATE_W'(c_q.y) >= -ONE_S)); // R7
    AST_Y_FOLLOWS_X: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.x <= ONE_S) && (c_q.x >= -ONE_S)) |-> (STATE_W'(c_q.y) == c_q.x)); // R7
    AST_LOAD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (c_q.x == STATE_W'($past(x_init)))); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(c_q.x)); // R9
endmodule

// File: rtl/cnn1d_array.sv
module cnn1d_array #(
    parameter int NCELL   = cnn1d_pkg::NCELL_DEF,
    parameter int W       = cnn1d_pkg::DATA_W_DEF,
    parameter int FRAC    = cnn1d_pkg::FRAC_W_DEF,
    parameter int SUM_W   = cnn1d_pkg::SUM_W_DEF,
    parameter int STATE_W = cnn1d_pkg::STATE_W_DEF,
    parameter int STEP_SH = cnn1d_pkg::STEP_SH_DEF,
    parameter int ADDR_W  = $clog2(cnn1d_pkg::ADDR_IN0 + 2 * NCELL)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [W-1:0]         cfg_wdata,
    input  logic                 start,
    output logic                 busy,
    output logic                 done,
    output logic [NCELL*W-1:0]   cell_y,
    output logic [NCELL*W-1:0]   cell_x
);
    import cnn1d_pkg::*;
    localparam int ADDR_X0 = ADDR_IN0 + NCELL;

    typedef struct packed {
        logic [2:0][W-1:0]       fb;
        logic [2:0][W-1:0]       ct;
        logic [W-1:0]            bias;
        logic [W-1:0]            iters;
        logic [NCELL-1:0][W-1:0] u;
        logic [NCELL-1:0][W-1:0] x0;
        logic [W-1:0]            cnt;
        logic                    busy;
        logic                    done;
    } ctl_t;

    ctl_t r_d, r_q;
    logic load_d, step_d;

    always_comb begin
        r_d    = r_q;
        load_d = 1'b0;
        step_d = 1'b0;
        if (start) begin
            load_d   = 1'b1;
            r_d.cnt  = '0;
            r_d.busy = (r_q.iters != '0);
            r_d.done = (r_q.iters == '0);
        end else if (r_q.busy) begin
            step_d  = 1'b1;
            r_d.cnt = r_q.cnt + 1'b1;
            if (W'(r_q.cnt + 1'b1) == r_q.iters) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end
        end else if (cfg_we) begin
            for (int k = 0; k < 3; k++) begin
                if (int'(cfg_addr) == ADDR_FB0 + k) r_d.fb[k] = cfg_wdata;
                if (int'(cfg_addr) == ADDR_CT0 + k) r_d.ct[k] = cfg_wdata;
            end
            if (int'(cfg_addr) == ADDR_BIAS) r_d.bias  = cfg_wdata;
            if (int'(cfg_addr) == ADDR_ITER) r_d.iters = cfg_wdata;
            for (int k = 0; k < NCELL; k++) begin
                if (int'(cfg_addr) == ADDR_IN0 + k) r_d.u[k]  = cfg_wdata;
                if (int'(cfg_addr) == ADDR_X0 + k)  r_d.x0[k] = cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy = r_q.busy;
    assign done = r_q.done;

    logic signed [W-1:0] y_w [NCELL];

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        logic signed [W-1:0]     y_l, y_r, u_l, u_r, x_o;
        logic signed [SUM_W-1:0] s_fb, s_ct;

        if (i == 0) begin : g_lo
            assign y_l = '0;
            assign u_l = '0;
        end else begin : g_lo
            assign y_l = y_w[i-1];
            assign u_l = r_q.u[i-1];
        end
        if (i == NCELL - 1) begin : g_hi
            assign y_r = '0;
            assign u_r = '0;
        end else begin : g_hi
            assign y_r = y_w[i+1];
            assign u_r = r_q.u[i+1];
        end

        cnn1d_tap3 #(.W(W), .FRAC(FRAC), .SUM_W(SUM_W)) u_fb (
            .w_l(r_q.fb[0]), .w_c(r_q.fb[1]), .w_r(r_q.fb[2]),
            .v_l(y_l), .v_c(y_w[i]), .v_r(y_r), .res(s_fb));

        cnn1d_tap3 #(.W(W), .FRAC(FRAC), .SUM_W(SUM_W)) u_ct (
            .w_l(r_q.ct[0]), .w_c(r_q.ct[1]), .w_r(r_q.ct[2]),
            .v_l(u_l), .v_c(r_q.u[i]), .v_r(u_r), .res(s_ct));

        cnn1d_cell #(.W(W), .FRAC(FRAC), .SUM_W(SUM_W), .STATE_W(STATE_W),
                     .STEP_SH(STEP_SH)) u_cell (
            .clk(clk), .rst_n(rst_n), .load(load_d), .step(step_d),
            .x_init(r_q.x0[i]), .fb_sum(s_fb), .ct_sum(s_ct), .bias(r_q.bias),
            .x_out(x_o), .y_out(y_w[i]));

        assign cell_y[i*W +: W] = y_w[i];
        assign cell_x[i*W +: W] = x_o;
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy && cfg_we) |=> ($stable(r_q.fb) && $stable(r_q.ct) && $stable(r_q.bias)
                                  && $stable(r_q.u) && $stable(r_q.iters))); // R3
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (r_q.cnt == '0)); // R4
    AST_DONE_AT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.done) |-> (r_q.cnt == r_q.iters)); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.done && r_q.busy)); // R9
endmodule

// File: tb/tb_cnn1d_array.sv
module tb_cnn1d_array;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 8;
    localparam int W  = 16;
    localparam int SH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [W-1:0] cfg_wdata = '0;
    logic start = 1'b0;
    logic busy, done;
    logic [NC*W-1:0] cell_y, cell_x;

    int total = 0;
    int fails = 0;

    int ta[3], tb[3], tbias, titers;
    int tu[NC], tx0[NC];
    longint xs[NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    cnn1d_array dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start), .busy(busy), .done(done),
        .cell_y(cell_y), .cell_x(cell_x));

    function automatic longint clampv(longint v, longint lo, longint hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic longint tap3(int w0, int w1, int w2, longint v0, longint v1, longint v2);
        longint s;
        s = ((longint'(w0) * v0) >>> 12) + ((longint'(w1) * v1) >>> 12) + ((longint'(w2) * v2) >>> 12);
        return clampv(s, -131072, 131071);
    endfunction

    task automatic model_run(int n);
        longint ys[NC];
        longint nx[NC];
        for (int k = 0; k < NC; k++) xs[k] = tx0[k];
        for (int it = 0; it < n; it++) begin
            for (int k = 0; k < NC; k++) ys[k] = clampv(xs[k], -4096, 4096);
            for (int k = 0; k < NC; k++) begin
                longint sa, sb, inc;
                sa = tap3(ta[0], ta[1], ta[2], (k == 0) ? 0 : ys[k-1], ys[k],
                          (k == NC-1) ? 0 : ys[k+1]);
                sb = tap3(tb[0], tb[1], tb[2], (k == 0) ? 0 : longint'(tu[k-1]), longint'(tu[k]),
                          (k == NC-1) ? 0 : longint'(tu[k+1]));
                inc = -xs[k] + sa + sb + tbias;
                nx[k] = xs[k] + (inc >>> SH);
            end
            for (int k = 0; k < NC; k++) xs[k] = nx[k];
        end
    endtask

    function automatic int get_x(int k);
        return int'($signed(cell_x[k*W +: W]));
    endfunction
    function automatic int get_y(int k);
        return int'($signed(cell_y[k*W +: W]));
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        cfg_we = 1'b1;
        cfg_addr = 5'(a);
        cfg_wdata = W'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_all();
        for (int k = 0; k < 3; k++) wr(k, ta[k]);
        for (int k = 0; k < 3; k++) wr(3 + k, tb[k]);
        wr(6, tbias);
        wr(7, titers);
        for (int k = 0; k < NC; k++) wr(8 + k, tu[k]);
        for (int k = 0; k < NC; k++) wr(16 + k, tx0[k]);
    endtask

    function automatic int rnd(int r);
        return int'($urandom_range(2 * r, 0)) - r;
    endfunction

    // poke: drive writes during the run that must not take effect
    task automatic run_case(string name, bit poke);
        bit early;
        int hold_x[NC];
        write_all();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < NC; k++) begin
            chk(get_x(k) == tx0[k], "R4", {name, " x after load"}, get_x(k), tx0[k]);
            chk(get_y(k) == clampv(tx0[k], -4096, 4096), "R4", {name, " y after load"},
                get_y(k), clampv(tx0[k], -4096, 4096));
        end
        chk(done == (titers == 0), "R9", {name, " done after start"}, done, titers == 0);
        chk(busy == (titers != 0), "R9", {name, " busy after start"}, busy, titers != 0);
        early = 1'b0;
        for (int c = 1; c <= titers; c++) begin
            if (poke && c <= 2) begin
                cfg_we = 1'b1;
                cfg_addr = (c == 1) ? 5'd1 : 5'd6;
                cfg_wdata = W'($urandom_range(32767, 0));
            end
            @(negedge clk);
            cfg_we = 1'b0;
            if (c < titers && (done || !busy)) early = 1'b1;
        end
        chk(!early, "R9", {name, " done/busy during run"}, early, 0);
        chk(done && !busy, "R9", {name, " done at count"}, done, 1);
        model_run(titers);
        for (int k = 0; k < NC; k++) begin
            longint ex, ey;
            ex = clampv(xs[k], -32768, 32767);
            ey = clampv(xs[k], -4096, 4096);
            chk(get_x(k) == ex, poke ? "R3" : "R6", {name, " state"}, get_x(k), ex);
            chk(get_y(k) == ey, "R7", {name, " output"}, get_y(k), ey);
            hold_x[k] = get_x(k);
        end
        repeat (3) @(negedge clk);
        begin
            bit same;
            same = 1'b1;
            for (int k = 0; k < NC; k++) if (get_x(k) != hold_x[k]) same = 1'b0;
            chk(same && done, "R9", {name, " frozen after done"}, same, 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        fails++;
        $display("FAIL R9 watchdog expired: actual 0 expected 1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1D));
        #(CLK_PERIOD * 3);
        @(negedge clk);
        // R1: reset state
        for (int k = 0; k < NC; k++) begin
            chk(get_x(k) == 0, "R1", "reset state", get_x(k), 0);
            chk(get_y(k) == 0, "R1", "reset output", get_y(k), 0);
        end
        chk(!done && !busy, "R1", "reset flags", {done, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 boundary: only the left feedback tap, bias pushes cell 0
        ta = '{8192, 0, 0}; tb = '{0, 0, 4096}; tbias = 2048; titers = 12;
        for (int k = 0; k < NC; k++) begin tu[k] = (k % 2) ? 4096 : -4096; tx0[k] = 4096 - k * 1024; end
        run_case("boundary R5", 1'b0);

        // zero iterations: R9
        titers = 0;
        run_case("zero-iter", 1'b0);

        // saturate high and low: R8
        ta = '{0, 28672, 0}; tb = '{0, 0, 0}; tbias = 32767; titers = 250;
        for (int k = 0; k < NC; k++) begin tu[k] = 0; tx0[k] = 0; end
        run_case("sat-high R8", 1'b0);
        tbias = -32768;
        run_case("sat-low R8", 1'b0);

        // writes during run ignored: R3
        ta = '{2048, 4096, -2048}; tb = '{1024, 4096, 1024}; tbias = -512; titers = 20;
        for (int k = 0; k < NC; k++) begin tu[k] = rnd(4096); tx0[k] = rnd(4096); end
        run_case("busy-writes R3", 1'b1);

        // unmapped address stores nothing, R2
        wr(30, 12345);
        run_case("unmapped R2", 1'b0);

        // random configurations, R2 R5 R6 R7
        for (int n = 0; n < 14; n++) begin
            for (int k = 0; k < 3; k++) begin ta[k] = rnd(8192); tb[k] = rnd(8192); end
            tbias = rnd(4096);
            titers = int'($urandom_range(60, 1));
            for (int k = 0; k < NC; k++) begin tu[k] = rnd(4096); tx0[k] = rnd(4096); end
            run_case("random R6", 1'b0);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule